// File: doc/BRIEF.md
# Cascadable Serial Multi-Channel Register Loader

This block takes 12-bit command words from a three-wire serial link made of a data line, a shift clock and a load strobe. It holds twelve 8-bit setting registers. Each command carries an 8-bit value and a 4-bit channel number. When the load strobe rises, the value goes into the register that the channel number picks. The twelve registers drive twelve parallel 8-bit outputs, for example to set the levels of a bank of converters or trim controls.

All three serial inputs are sampled into the system clock through two-flop synchronizers. Rising edges of the shift clock and of the strobe are found inside the block, so the whole design runs in one clock domain.

A cascade output carries the bit in the far stage of the shift chain. Several loaders can therefore share one clock and strobe in a daisy chain, each one passing the stream on 12 shifts later.

A small controller makes sure that one strobe causes exactly one write. Its states are:
- `ST_SHIFT`: waiting, strobe low.
- `ST_COMMIT`: a one-cycle write.
- `ST_HOLD`: the strobe is still high after the write.

Its transitions are:
- SHIFT→COMMIT on a strobe rising edge.
- COMMIT→HOLD while the strobe stays high.
- COMMIT→SHIFT when the strobe is already low.
- HOLD→SHIFT when the strobe falls.

Top module: `serial_chan_loader`

## Requirements
- R1: Each synchronized rising edge of `ser_clk_i` shifts `ser_data_i` into stage D0 of a 12-stage chain and moves every stage up by one. After 12 shifts, the first bit sent sits in D11.
- R2: The value field is D7..D0, with D0 as the least significant bit. D0 is the last bit sent.
- R3: The select field is the 4-bit code {D8,D9,D10,D11}, with D8 as the most significant bit. Codes 1 to 12 write channel 1 to 12. Channel n is `chan_code_o[(n-1)*8 +: 8]`.
- R4: Select codes 0, 13, 14 and 15 change no channel register.
- R5: The write happens once, on the rising edge of the load strobe. Shift-clock edges that arrive while the strobe is high still shift the chain, but they do not change any channel.
- R6: `cascade_o` shows stage D11. A following device therefore sees the input stream delayed by 12 shifts.
- R7: A synchronous active-high `rst` clears the chain and all twelve channel registers to zero.
- R8: A write changes only the addressed channel. All other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial shift clock; its rising edge shifts |
| ser_load_i | input | 1 | Load strobe; its rising edge writes |
| cascade_o | output | 1 | Far stage (D11) of the shift chain |
| chan_code_o | output | 96 | Twelve 8-bit channel values; channel n at bits (n-1)*8 +: 8 |

## Verification
Every channel is written with a different, asymmetric value, such as 8'h01 against 8'h80. This shows whether the value field is reversed and whether the select field is read the wrong way round, since code 1 and code 8 are mirror images. Frames with select codes 0, 13, 14 and 15 must leave all twelve outputs as they were. A frame shifted in while the strobe is still high must not overwrite the channel that was just loaded. Its bits must still reach the cascade output, which is compared bit by bit against the earlier frame as the next frame pushes it out.

// File: rtl/loader_pkg.sv
package loader_pkg;
    localparam int FRAME_W = 12;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = FRAME_W - DATA_W;
    localparam int NUM_CH  = 12;

    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } load_state_t;
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
    end

    assign level_o = sync_q;
endmodule

// File: rtl/loader_shift.sv
module loader_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[W-2:0], bit_i};
        end
    end

    assign word_o = chain_q;
endmodule

// File: rtl/loader_bank.sv
module loader_bank #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        data,
    output logic [NUM_CH*DATA_W-1:0] chan_o
);
    logic [DATA_W-1:0] reg_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [SEL_W-1:0] CODE = SEL_W'(c + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q[c] <= '0;
            end else if (wr_en && (sel == CODE)) begin
                reg_q[c] <= data;
            end
        end
        assign chan_o[c*DATA_W +: DATA_W] = reg_q[c];
    end
endmodule

// File: rtl/serial_chan_loader.sv
module serial_chan_loader
    import loader_pkg::*;
#(
    parameter int P_FRAME_W = FRAME_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_NUM_CH  = NUM_CH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_data_i,
    input  logic                         ser_clk_i,
    input  logic                         ser_load_i,
    output logic                         cascade_o,
    output logic [P_NUM_CH*P_DATA_W-1:0] chan_code_o
);
    localparam int P_SEL_W = P_FRAME_W - P_DATA_W;

    logic [2:0] lvl_w, rise_w;
    logic [P_FRAME_W-1:0] word_w;
    logic [P_SEL_W-1:0]   sel_w;
    logic wr_en;
    load_state_t state_q, state_d;

    loader_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_load_i, ser_clk_i, ser_data_i}),
        .level_o (lvl_w),
        .rise_o  (rise_w)
    );

    loader_shift #(.W(P_FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rise_w[1]),
        .bit_i    (lvl_w[0]),
        .word_o   (word_w)
    );

    // select field: D8 is the most significant bit, D11 the least
    for (genvar k = 0; k < P_SEL_W; k++) begin : g_sel
        assign sel_w[k] = word_w[P_FRAME_W-1-k];
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SHIFT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_SHIFT:  if (rise_w[2]) state_d = ST_COMMIT;
            ST_COMMIT: begin
                wr_en   = 1'b1;
                state_d = lvl_w[2] ? ST_HOLD : ST_SHIFT;
            end
            ST_HOLD:   if (!lvl_w[2]) state_d = ST_SHIFT;
            default:   state_d = ST_SHIFT;
        endcase
    end

    loader_bank #(
        .NUM_CH (P_NUM_CH),
        .DATA_W (P_DATA_W),
        .SEL_W  (P_SEL_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel_w),
        .data   (word_w[P_DATA_W-1:0]),
        .chan_o (chan_code_o)
    );

    assign cascade_o = word_w[P_FRAME_W-1];
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [SEL_W-1:0]         sel,
    input logic [NUM_CH*DATA_W-1:0] chan
);
    // R7
    a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (chan == '0));

    // R5
    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(chan));

    // R4
    a_r4_dontcare_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == '0 || int'(sel) > NUM_CH)) |=> $stable(chan));
endmodule

bind serial_chan_loader loader_checker #(
    .NUM_CH (P_NUM_CH),
    .DATA_W (P_DATA_W),
    .SEL_W  (P_SEL_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .sel   (sel_w),
    .chan  (chan_code_o)
);

// File: tb/serial_chan_loader_tb.sv
module serial_chan_loader_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdat = 1'b0, sclk = 1'b0, sload = 1'b0;
    logic casc;
    logic [95:0] chan;
    logic [7:0] exp_q [12];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_chan_loader dut_i (
        .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk),
        .ser_load_i(sload), .cascade_o(casc), .chan_code_o(chan)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 12; c++)
            chk(req, {24'd0, chan[c*8 +: 8]}, {24'd0, exp_q[c]});
    endtask

    function automatic logic [11:0] mk(input logic [3:0] ch, input logic [7:0] v);
        logic [11:0] w;
        w[7:0] = v;
        w[8] = ch[3]; w[9] = ch[2]; w[10] = ch[1]; w[11] = ch[0];
        return w;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); sdat = b;
        repeat (4) @(negedge clk); sclk = 1'b1;
        repeat (4) @(negedge clk); sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe();
        @(negedge clk); sload = 1'b1;
        repeat (8) @(negedge clk); sload = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 12; c++) exp_q[c] = 8'h00;
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R7 reset");
        chk("R7 cascade reset", {31'd0, casc}, 32'd0);
    endtask

    task automatic t_all_channels();
        for (int c = 1; c <= 12; c++) begin
            logic [7:0] v;
            v = (c == 1) ? 8'h01 : (c == 8) ? 8'h80 : 8'(c * 8'h13 + 8'h05);
            send_word(mk(4'(c), v));
            strobe();
            exp_q[c-1] = v;
            check_all("R3 R2 R8 channel write");
        end
    endtask

    task automatic t_dontcare();
        logic [3:0] codes [4] = '{4'd0, 4'd13, 4'd14, 4'd15};
        for (int k = 0; k < 4; k++) begin
            send_word(mk(codes[k], 8'h5A));
            strobe();
            check_all("R4 ignored code");
        end
    endtask

    task automatic t_load_high_and_cascade();
        logic [11:0] a, b;
        a = mk(4'd3, 8'hC3);
        b = mk(4'd3, 8'h3C);
        send_word(a);
        @(negedge clk); sload = 1'b1;
        repeat (8) @(negedge clk);
        exp_q[2] = 8'hC3;
        // R5: shift frame b while the strobe stays high
        for (int i = 11; i >= 0; i--) begin
            chk("R6 cascade", {31'd0, casc}, {31'd0, a[i]});
            send_bit(b[i]);
        end
        check_all("R5 no write while load high");
        sload = 1'b0;
        repeat (6) @(negedge clk);
        check_all("R5 after load fall");
        // R1: frame b now fully in the chain; push it out and observe
        for (int i = 11; i >= 0; i--) begin
            chk("R1 R6 shifted b", {31'd0, casc}, {31'd0, b[i]});
            send_bit(1'b0);
        end
    endtask

    initial begin
        for (int c = 0; c < 12; c++) exp_q[c] = 8'h00;
        repeat (2) @(negedge clk);
        t_reset();
        t_all_channels();
        t_dontcare();
        t_load_high_and_cascade();
        t_reset();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule